// File: doc/BRIEF.md
# UART control and flow-control unit

This unit holds the 32-bit control word of a UART and turns it, together with status from the serial datapath, into the permissions that datapath obeys. It decides when the transmitter may start a new character, whether the receiver may run, what level the RTS and DTR lines carry, and how the serial lines are routed when the internal loopback is selected. The baud generator, the shift engines and the FIFOs sit outside. They report to this unit only through busy flags, a transmit-FIFO-not-empty flag and a count of free receive-FIFO entries.

Software turns the UART off by clearing the global enable. Any character already in flight is allowed to finish. Once both directions report idle, the `stopped` output rises, and software waits for it before rewriting the control word. Transmit can be held off by the remote CTS line, and RTS can be driven from free space in the receive FIFO. Each of these two flow-control features has its own enable bit.

Top module: `uart_ctl_unit`

## Requirements
- R1: After reset the control word reads 0x0000_0300 (bit 8 transmit enable and bit 9 receive enable set, all else 0). With that word the outputs are: `tx_start_ok` 0, `rx_enable` 0, `rts_n` 1, `dtr` 0 and `stopped` 1 (when both busy flags are 0).
- R2: A write on `reg_wr` stores only bits 15, 14, 11, 10, 9, 8, 7, 5, 4, 1 and 0 (write mask 0x0000_CFB3). All other bits read as 0. The stored word is visible on `reg_rdata` from the cycle after the write edge.
- R3: `tx_start_ok` is 1 only when all of the following hold: bit 0 (global enable) is 1, bit 8 (transmit enable) is 1, `tx_fifo_nonempty` is 1, and `tx_busy` is 0.
- R4: When bit 15 (CTS flow control) is 1, `tx_start_ok` also needs the active-low `cts_n` to be 0. `cts_n` passes through two flops, so a change on it reaches `tx_start_ok` after the second rising edge. A CTS change during a busy character never affects that character.
- R5: `rx_enable` is 1 whenever bit 0 and bit 9 are both 1.
- R6: A receive already under way when the enables drop completes. If `rx_enable` was 1 and `rx_busy` stays 1, `rx_enable` stays 1 until `rx_busy` falls. It cannot be raised again by `rx_busy` alone. No new transmit start is granted after bit 0 clears.
- R7: With bit 14 (RTS flow control) set, the active-low `rts_n` is 0 exactly when `rx_free_cnt` is nonzero. With bit 14 clear, `rts_n` is the inverse of bit 11. `dtr` always equals bit 10.
- R8: With bit 7 (loopback) set, `rx_serial` equals `tx_serial` and `tx_pin` is held at 1. With bit 7 clear, `rx_serial` equals `rx_pin` and `tx_pin` equals `tx_serial`.
- R9: `stopped` is 1 exactly when bit 0 is 0 and both `tx_busy` and `rx_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| tx_busy | input | 1 | Transmitter is sending a character |
| rx_busy | input | 1 | Receiver is taking in a character |
| tx_fifo_nonempty | input | 1 | Transmit FIFO holds data |
| rx_free_cnt | input | FREE_W | Free receive FIFO entries |
| cts_n | input | 1 | Clear-to-send from the line, active low |
| tx_start_ok | output | 1 | Transmitter may begin a character |
| rx_enable | output | 1 | Receiver may run |
| rts_n | output | 1 | Request-to-send to the line, active low |
| dtr | output | 1 | Data-terminal-ready level |
| tx_serial | input | 1 | Serial data from the transmit shifter |
| rx_pin | input | 1 | External receive pin |
| tx_pin | output | 1 | External transmit pin |
| rx_serial | output | 1 | Serial data to the receive shifter |
| stopped | output | 1 | UART disabled and idle |

## Verification
The bench builds the unit with the default `FREE_W` of 5. With that width the free-entry count can be driven both to zero and to several nonzero values, so RTS flow control is seen both asserting and holding off. A 32-bit write pattern covers every reserved bit, including the upper half. The directed part walks a disable while both directions are busy, releases the busy flags one at a time, and steps CTS edge by edge to pin down the two-cycle synchronizer delay.

// File: rtl/uart_ctl_unit.sv
module uart_ctl_unit #(
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_busy,
  input  logic              rx_busy,
  input  logic              tx_fifo_nonempty,
  input  logic [FREE_W-1:0] rx_free_cnt,
  input  logic              cts_n,
  output logic              tx_start_ok,
  output logic              rx_enable,
  output logic              rts_n,
  output logic              dtr,
  input  logic              tx_serial,
  input  logic              rx_pin,
  output logic              tx_pin,
  output logic              rx_serial,
  output logic              stopped
);
  localparam logic [31:0] WR_MASK  = 32'h0000_CFB3;
  localparam logic [31:0] RST_WORD = 32'h0000_0300;

  localparam int B_EN    = 0;
  localparam int B_LOOP  = 7;
  localparam int B_TXE   = 8;
  localparam int B_RXE   = 9;
  localparam int B_DTR   = 10;
  localparam int B_RTS   = 11;
  localparam int B_RTSFC = 14;
  localparam int B_CTSFC = 15;

  logic [31:0] ctl;
  logic [1:0]  cts_sync;
  logic        rx_was_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= RST_WORD;
    else if (reg_wr) ctl <= reg_wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_sync <= 2'b11;
    else cts_sync <= {cts_sync[0], cts_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_was_on <= 1'b0;
    else rx_was_on <= rx_enable;
  end

  wire cts_clear = ~cts_sync[1] | ~ctl[B_CTSFC];

  assign reg_rdata   = ctl;
  assign tx_start_ok = ctl[B_EN] & ctl[B_TXE] & tx_fifo_nonempty & ~tx_busy & cts_clear;
  assign rx_enable   = (ctl[B_EN] & ctl[B_RXE]) | (rx_busy & rx_was_on);
  assign rts_n       = ctl[B_RTSFC] ? ~(|rx_free_cnt) : ~ctl[B_RTS];
  assign dtr         = ctl[B_DTR];
  assign tx_pin      = ctl[B_LOOP] ? 1'b1 : tx_serial;
  assign rx_serial   = ctl[B_LOOP] ? tx_serial : rx_pin;
  assign stopped     = ~ctl[B_EN] & ~tx_busy & ~rx_busy;
endmodule

module uart_ctl_unit_chk #(
  parameter int FREE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       reg_rdata,
  input logic              tx_busy,
  input logic              rx_busy,
  input logic [FREE_W-1:0] rx_free_cnt,
  input logic              cts_n,
  input logic              tx_start_ok,
  input logic              rx_enable,
  input logic              rts_n,
  input logic              tx_pin,
  input logic              stopped
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~32'h0000_CFB3) == 32'h0)
    else $error("R2 reserved bit set");

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_ok |-> (reg_rdata[0] && reg_rdata[8] && !tx_busy))
    else $error("R3 start without permission");

  assert_cts_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_ok && reg_rdata[15]) |-> ($past(cts_n, 2) == 1'b0))
    else $error("R4 start while CTS deasserted");

  assert_rx_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && $past(rx_enable) && $past(rx_busy)) |-> rx_enable)
    else $error("R6 receive cut short");

  assert_rts_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[14] && rx_free_cnt == '0) |-> rts_n)
    else $error("R7 RTS asserted with full FIFO");

  assert_loop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] |-> tx_pin)
    else $error("R8 TX pin not idle in loopback");

  assert_stopped_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!tx_busy && !rx_busy && !reg_rdata[0] && !tx_start_ok))
    else $error("R9 stopped while active");
endmodule

bind uart_ctl_unit uart_ctl_unit_chk #(.FREE_W(FREE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .tx_busy(tx_busy),
  .rx_busy(rx_busy), .rx_free_cnt(rx_free_cnt), .cts_n(cts_n),
  .tx_start_ok(tx_start_ok), .rx_enable(rx_enable), .rts_n(rts_n),
  .tx_pin(tx_pin), .stopped(stopped)
);

// File: tb/test_uart_ctl_unit.sv
module test_uart_ctl_unit;
  localparam int FREE_W = 5;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_busy = 0, rx_busy = 0, tx_fifo_nonempty = 0;
  logic [FREE_W-1:0] rx_free_cnt = '0;
  logic cts_n = 1, tx_serial = 1, rx_pin = 1;
  logic tx_start_ok, rx_enable, rts_n, dtr, tx_pin, rx_serial, stopped;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_ctl_unit #(.FREE_W(FREE_W)) i_uart_ctl_unit (.*);

  typedef struct packed {
    logic [31:0] wdata;
    logic        cts_n, txb, rxb, txne;
    logic [4:0]  free;
    logic        txs, rxp;
    logic        e_start, e_rxen, e_rts_n, e_dtr, e_txpin, e_rxser, e_stop;
    logic [31:0] e_rdata;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0301, 1'b1,1'b0,1'b0,1'b1, 5'd3, 1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0000_0301},
    '{32'h0000_8301, 1'b1,1'b0,1'b0,1'b1, 5'd3, 1'b1,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0000_8301},
    '{32'h0000_8301, 1'b0,1'b0,1'b0,1'b1, 5'd3, 1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0000_8301},
    '{32'h0000_4301, 1'b1,1'b0,1'b0,1'b1, 5'd0, 1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0000_4301},
    '{32'h0000_4301, 1'b1,1'b0,1'b0,1'b1, 5'd5, 1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_4301},
    '{32'h0000_0C00, 1'b1,1'b0,1'b0,1'b1, 5'd0, 1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 32'h0000_0C00},
    '{32'h0000_FFFF, 1'b0,1'b0,1'b0,1'b1, 5'd2, 1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 32'h0000_CFB3},
    '{32'h0000_0081, 1'b1,1'b0,1'b0,1'b1, 5'd0, 1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h0000_0081},
    '{32'h0000_0301, 1'b1,1'b1,1'b0,1'b1, 5'd1, 1'b1,1'b1, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h0000_0301},
    '{32'h0000_0301, 1'b1,1'b0,1'b0,1'b0, 5'd1, 1'b1,1'b1, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h0000_0301},
    '{32'h0000_0000, 1'b1,1'b0,1'b0,1'b1, 5'd1, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 32'h0000_0000},
    '{32'h0000_0000, 1'b1,1'b1,1'b0,1'b1, 5'd1, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h0000_0000},
    '{32'hFFFF_304C, 1'b1,1'b0,1'b0,1'b1, 5'd1, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 word", reg_rdata, 32'h0000_0300);
    check("R1 start", {31'b0, tx_start_ok}, 32'd0);
    check("R1 rxen", {31'b0, rx_enable}, 32'd0);
    check("R1 rts_n", {31'b0, rts_n}, 32'd1);
    check("R1 dtr", {31'b0, dtr}, 32'd0);
    check("R1 stopped", {31'b0, stopped}, 32'd1);

    // Table: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      cts_n = v.cts_n; tx_busy = v.txb; rx_busy = v.rxb; tx_fifo_nonempty = v.txne;
      rx_free_cnt = v.free; tx_serial = v.txs; rx_pin = v.rxp;
      write_ctl(v.wdata);
      @(negedge clk); @(negedge clk);
      check($sformatf("R2 rdata v%0d", i), reg_rdata, v.e_rdata);
      check($sformatf("R3/R4 start v%0d", i), {31'b0, tx_start_ok}, {31'b0, v.e_start});
      check($sformatf("R5 rxen v%0d", i), {31'b0, rx_enable}, {31'b0, v.e_rxen});
      check($sformatf("R7 rts/dtr v%0d", i), {30'b0, rts_n, dtr}, {30'b0, v.e_rts_n, v.e_dtr});
      check($sformatf("R8 lines v%0d", i), {30'b0, tx_pin, rx_serial}, {30'b0, v.e_txpin, v.e_rxser});
      check($sformatf("R9 stopped v%0d", i), {31'b0, stopped}, {31'b0, v.e_stop});
    end

    // R4 synchronizer latency
    tx_busy = 0; rx_busy = 0; tx_fifo_nonempty = 1; cts_n = 1;
    write_ctl(32'h0000_8301);
    @(negedge clk); @(negedge clk);
    check("R4 blocked", {31'b0, tx_start_ok}, 32'd0);
    cts_n = 0;
    @(negedge clk);
    check("R4 after one edge", {31'b0, tx_start_ok}, 32'd0);
    @(negedge clk);
    check("R4 after two edges", {31'b0, tx_start_ok}, 32'd1);
    tx_busy = 1; cts_n = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R4 busy during cts drop", {31'b0, tx_start_ok}, 32'd0);
    tx_busy = 0;
    @(negedge clk);
    check("R4 next char held", {31'b0, tx_start_ok}, 32'd0);

    // R6 graceful disable
    cts_n = 0;
    write_ctl(32'h0000_0301);
    tx_busy = 1; rx_busy = 1;
    @(negedge clk);
    write_ctl(32'h0000_0000);
    check("R6 rx held", {31'b0, rx_enable}, 32'd1);
    check("R6 no start", {31'b0, tx_start_ok}, 32'd0);
    check("R9 not yet stopped", {31'b0, stopped}, 32'd0);
    tx_busy = 0;
    @(negedge clk);
    check("R6 rx still held", {31'b0, rx_enable}, 32'd1);
    check("R6 no start after tx idle", {31'b0, tx_start_ok}, 32'd0);
    check("R9 rx busy", {31'b0, stopped}, 32'd0);
    rx_busy = 0;
    @(negedge clk);
    check("R6 rx released", {31'b0, rx_enable}, 32'd0);
    check("R9 stopped", {31'b0, stopped}, 32'd1);
    rx_busy = 1;
    @(negedge clk); @(negedge clk);
    check("R6 busy alone no enable", {31'b0, rx_enable}, 32'd0);
    rx_busy = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule